// File: doc/BRIEF.md
# Wiper Setting Store Controller

This block keeps a small array of nonvolatile 16-bit entries behind a set of volatile wiper position registers. The first entries hold the saved power-up position of each wiper, the next entries are free user storage, and the last entry is reserved and fixed. The controller loads each wiper from its saved entry after reset. It also honours an active-low hardware preset pin, which parks the wipers at midscale while held and reloads the saved positions when it is released. An active-low write-protect pin freezes the wipers and the store, but recalls from the store still go through.

Commands reach the block already decoded: a valid strobe with an opcode, an address and 16 data bits. A command is accepted only in a cycle where `ready` is high. The slow operations, which are stores, bulk recall, reads and the preset release, pull `ready` low for a fixed number of clock cycles set by a parameter. The store is an on-chip register array that reset does not clear, so saved values survive a reset in the way they would survive a power cycle.

Top module: `nv_setting_ctrl`

## Requirements
- R1: Entry k (k < NUM_CH) holds the saved position of wiper k. Entries NUM_CH to DEPTH-2 are user storage. Entry DEPTH-1 always reads the midscale value, and a data-store to that address is dropped without lowering `ready`.
- R2: Entries that were never written read as midscale (512 at default widths). In the first clock after `rst_n` is released, every wiper loads the low bits of its saved entry and `ready` goes high. While `rst_n` is low the wipers are at midscale and `ready` is low.
- R3: Each clock edge that samples `preset_n` low sets all wipers to midscale, and `ready` is low in the following cycle. At the first edge that samples it high again, the wipers load their saved entries and `ready` stays low for LAT_PRESET cycles.
- R4: With `wprot_n` low, write-wiper, save and data-store commands are ignored and `ready` stays high. Single restore, restore-all and the preset release still load the saved values into the wipers.
- R5: After an accepted command, `ready` is low for exactly LAT_STORE cycles for save and data-store, LAT_RESTORE_ALL cycles for restore-all, and LAT_READ cycles for both reads. It does not drop for nop, restore or write-wiper.
- R6: When a wiper is loaded from its entry, only the low WIPER_W bits of that 16-bit entry are used.
- R7: An accepted restore (op 1) sets `read_power`. An accepted nop (op 0) clears it. No other command changes it.
- R8: A command is accepted only at an edge where `ready` is high and `preset_n` is high. Otherwise it has no effect on the wipers, the store, `rd_data` or `read_power`.
- R9: Sources that move the wipers are ranked: the post-reset load first, then the preset pin, then commands. If the preset pin is low at the first edge after reset, the saved values load first and midscale follows one edge later.
- R10: Opcodes on `cmd_op` are: 0 nop, 1 restore wiper addr[0] from its entry, 2 save wiper addr[0] into its entry (zero-extended), 3 store `cmd_data` at `cmd_addr`, 4 restore all wipers, 5 read entry `cmd_addr`, 6 read wiper addr[0] (zero-extended), 7 write `cmd_data[WIPER_W-1:0]` to wiper addr[0]. Each result appears on the outputs in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| preset_n | input | 1 | Hardware preset, active low |
| wprot_n | input | 1 | Write protect, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Decoded opcode (see R10) |
| cmd_addr | input | ADDR_W (4) | Entry or wiper address |
| cmd_data | input | DATA_W (16) | Command data |
| wiper_pos | output | NUM_CH x WIPER_W (2 x 10) | Wiper position registers |
| ready | output | 1 | High when a command can be accepted |
| rd_data | output | DATA_W (16) | Result of the last read command |
| read_power | output | 1 | Higher-power read state flag |

## Verification
Every output is registered, so every effect of an accepted command, of the preset edge and of the reset release is due at the first falling clock edge after the accepting rising edge. The bench drives inputs and samples outputs only on falling edges. Busy windows are measured by counting the falling edges that see `ready` low after that first one, and the count must equal the latency parameter. A behavioural model advances on each rising edge from the same sampled inputs, and every output is compared against it on every falling edge. Targeted checks also sample wipers, `rd_data` and `read_power` at the due edge.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   typedef enum logic [2:0] {
      OP_NOP         = 3'd0,
      OP_RESTORE     = 3'd1,
      OP_SAVE        = 3'd2,
      OP_STORE       = 3'd3,
      OP_RESTORE_ALL = 3'd4,
      OP_READ_STORE  = 3'd5,
      OP_READ_WIPER  = 3'd6,
      OP_WRITE_WIPER = 3'd7
   } nvs_op_e;

   typedef enum logic [2:0] {
      LC_NONE,
      LC_STORE,
      LC_RALL,
      LC_READ,
      LC_PRESET
   } lat_cls_e;

   // latency class used by each accepted command
   function automatic lat_cls_e op_class(input nvs_op_e op);
      case (op)
         OP_SAVE, OP_STORE:            return LC_STORE;
         OP_RESTORE_ALL:               return LC_RALL;
         OP_READ_STORE, OP_READ_WIPER: return LC_READ;
         default:                      return LC_NONE;
      endcase
   endfunction

endpackage

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer
   import nvs_pkg::*;
#(
   parameter int unsigned LAT_STORE       = 3125000,
   parameter int unsigned LAT_RESTORE_ALL = 125000,
   parameter int unsigned LAT_READ        = 12500,
   parameter int unsigned LAT_PRESET      = 8750
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clear,
   input  logic     start,
   input  lat_cls_e cls,
   output logic     idle
);

   localparam int unsigned MAX_A = (LAT_STORE > LAT_RESTORE_ALL) ? LAT_STORE : LAT_RESTORE_ALL;
   localparam int unsigned MAX_B = (LAT_READ > LAT_PRESET) ? LAT_READ : LAT_PRESET;
   localparam int unsigned MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned CNT_W = $clog2(MAX_L + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_v;

   always_comb begin
      case (cls)
         LC_STORE:  load_v = CNT_W'(LAT_STORE);
         LC_RALL:   load_v = CNT_W'(LAT_RESTORE_ALL);
         LC_READ:   load_v = CNT_W'(LAT_READ);
         LC_PRESET: load_v = CNT_W'(LAT_PRESET);
         default:   load_v = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clear)          cnt_q <= '0;
      else if (start)          cnt_q <= load_v;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign idle = (cnt_q == '0);

endmodule

// File: rtl/nvs_store.sv
module nvs_store #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned NUM_CH  = 2,
   parameter int unsigned WIPER_W = 10,
   parameter int unsigned INIT    = 512,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic                             clk,
   input  logic                             we,
   input  logic [ADDR_W-1:0]                waddr,
   input  logic [DATA_W-1:0]                wdata,
   input  logic [ADDR_W-1:0]                raddr,
   output logic [DATA_W-1:0]                rdata,
   output logic [NUM_CH-1:0][WIPER_W-1:0]   ch_pos
);

   localparam int unsigned RSV = DEPTH - 1;

   logic [DATA_W-1:0] row [DEPTH];

   // entries are not reset: they model nonvolatile cells
   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      if (e == RSV) begin : g_fixed
         assign row[e] = DATA_W'(INIT);
      end else begin : g_cell
         logic [DATA_W-1:0] cell_q = DATA_W'(INIT);
         always_ff @(posedge clk) begin
            if (we && (waddr == ADDR_W'(e))) cell_q <= wdata;
         end
         assign row[e] = cell_q;
      end
   end

   assign rdata = row[raddr];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chout
      assign ch_pos[c] = row[c][WIPER_W-1:0];
   end

endmodule

// File: rtl/nvs_wiper_ch.sv
module nvs_wiper_ch #(
   parameter int unsigned WIPER_W = 10,
   localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               force_mid,
   input  logic               load_en,
   input  logic [WIPER_W-1:0] load_val,
   input  logic               wr_en,
   input  logic [WIPER_W-1:0] wr_val,
   output logic [WIPER_W-1:0] pos
);

   always_ff @(posedge clk) begin
      if (!rst_n)         pos <= MID;
      else if (force_mid) pos <= MID;
      else if (load_en)   pos <= load_val;
      else if (wr_en)     pos <= wr_val;
   end

endmodule

// File: rtl/nv_setting_ctrl.sv
module nv_setting_ctrl
   import nvs_pkg::*;
#(
   parameter int unsigned DATA_W          = 16,
   parameter int unsigned WIPER_W         = 10,
   parameter int unsigned DEPTH           = 16,
   parameter int unsigned NUM_CH          = 2,
   parameter int unsigned LAT_STORE       = 3125000,
   parameter int unsigned LAT_RESTORE_ALL = 125000,
   parameter int unsigned LAT_READ        = 12500,
   parameter int unsigned LAT_PRESET      = 8750,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            preset_n,
   input  logic                            wprot_n,
   input  logic                            cmd_valid,
   input  logic [2:0]                      cmd_op,
   input  logic [ADDR_W-1:0]               cmd_addr,
   input  logic [DATA_W-1:0]               cmd_data,
   output logic [NUM_CH-1:0][WIPER_W-1:0]  wiper_pos,
   output logic                            ready,
   output logic [DATA_W-1:0]               rd_data,
   output logic                            read_power
);

   localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int unsigned MIDV = 1 << (WIPER_W - 1);
   localparam logic [ADDR_W-1:0] RSV_ADDR = ADDR_W'(DEPTH - 1);

   initial begin
      assert (WIPER_W <= DATA_W) else $error("wiper wider than entry");
      assert ((1 << CH_W) == NUM_CH || NUM_CH == 1) else $error("NUM_CH must be a power of two");
      assert (NUM_CH + 1 < DEPTH) else $error("store too small for channels");
      assert (ADDR_W >= CH_W) else $error("address narrower than channel select");
   end

   logic              pon_q;
   logic              pr_q;
   logic              rpw_q;
   logic [DATA_W-1:0] rd_q;
   logic              timer_idle;

   logic ph_hold, ph_rise, ph_run, acc;
   nvs_op_e           op;
   logic [CH_W-1:0]   ch_sel;
   logic              op_allowed;
   lat_cls_e          cls;
   logic              st_we;
   logic [ADDR_W-1:0] st_waddr;
   logic [DATA_W-1:0] st_wdata;
   logic [DATA_W-1:0] st_rdata;
   logic [NUM_CH-1:0][WIPER_W-1:0] saved_pos;
   logic [WIPER_W-1:0] sel_pos;

   assign op      = nvs_op_e'(cmd_op);
   assign ch_sel  = cmd_addr[CH_W-1:0];
   assign sel_pos = wiper_pos[ch_sel];

   // phase decode, highest priority first: post-reset load, preset hold,
   // preset release, command service
   assign ph_hold = !pon_q && !preset_n;
   assign ph_rise = !pon_q && preset_n && !pr_q;
   assign ph_run  = !pon_q && preset_n && pr_q;
   assign ready   = !pon_q && pr_q && timer_idle;
   assign acc     = ph_run && cmd_valid && timer_idle;

   always_comb begin
      case (op)
         OP_SAVE, OP_WRITE_WIPER: op_allowed = wprot_n;
         OP_STORE:                op_allowed = wprot_n && (cmd_addr != RSV_ADDR);
         default:                 op_allowed = 1'b1;
      endcase
   end

   assign st_we    = acc && op_allowed && ((op == OP_SAVE) || (op == OP_STORE));
   assign st_waddr = (op == OP_SAVE) ? ADDR_W'(ch_sel) : cmd_addr;
   assign st_wdata = (op == OP_SAVE) ? DATA_W'(sel_pos) : cmd_data;
   assign cls      = ph_rise ? LC_PRESET :
                     ((acc && op_allowed) ? op_class(op) : LC_NONE);

   nvs_busy_timer #(
      .LAT_STORE      (LAT_STORE),
      .LAT_RESTORE_ALL(LAT_RESTORE_ALL),
      .LAT_READ       (LAT_READ),
      .LAT_PRESET     (LAT_PRESET)
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(ph_hold),
      .start(ph_rise || acc),
      .cls  (cls),
      .idle (timer_idle)
   );

   nvs_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .NUM_CH (NUM_CH),
      .WIPER_W(WIPER_W),
      .INIT   (MIDV)
   ) u_store (
      .clk   (clk),
      .we    (st_we),
      .waddr (st_waddr),
      .wdata (st_wdata),
      .raddr (cmd_addr),
      .rdata (st_rdata),
      .ch_pos(saved_pos)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      logic ld;
      logic wr;
      assign hit = (ch_sel == CH_W'(c));
      assign ld  = pon_q || ph_rise ||
                   (acc && ((op == OP_RESTORE_ALL) || ((op == OP_RESTORE) && hit)));
      assign wr  = acc && op_allowed && (op == OP_WRITE_WIPER) && hit;

      nvs_wiper_ch #(
         .WIPER_W(WIPER_W)
      ) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .force_mid(ph_hold),
         .load_en  (ld),
         .load_val (saved_pos[c]),
         .wr_en    (wr),
         .wr_val   (cmd_data[WIPER_W-1:0]),
         .pos      (wiper_pos[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pon_q <= 1'b1;
         pr_q  <= 1'b1;
         rpw_q <= 1'b0;
         rd_q  <= '0;
      end else begin
         pon_q <= 1'b0;
         pr_q  <= preset_n;
         if (acc) begin
            case (op)
               OP_READ_STORE: rd_q  <= st_rdata;
               OP_READ_WIPER: rd_q  <= DATA_W'(sel_pos);
               OP_RESTORE:    rpw_q <= 1'b1;
               OP_NOP:        rpw_q <= 1'b0;
               default: ;
            endcase
         end
      end
   end

   assign rd_data    = rd_q;
   assign read_power = rpw_q;

endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
   parameter int unsigned WIPER_W = 10,
   parameter int unsigned NUM_CH  = 2
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           preset_n,
   input logic                           wprot_n,
   input logic                           cmd_valid,
   input logic [2:0]                     cmd_op,
   input logic [NUM_CH-1:0][WIPER_W-1:0] wiper_pos,
   input logic                           ready,
   input logic                           read_power
);

   localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

   logic started_q;
   logic acc;

   always_ff @(posedge clk) begin
      if (!rst_n) started_q <= 1'b0;
      else        started_q <= 1'b1;
   end

   assign acc = cmd_valid && ready && preset_n;

   AST_PRESET_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && !preset_n) |=> (wiper_pos == {NUM_CH{MID}})); // R3

   AST_PRESET_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !preset_n |=> !ready); // R3

   AST_WPROT_WIPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !wprot_n && cmd_op == 3'd7) |=> $stable(wiper_pos)); // R4

   AST_SAVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && wprot_n && cmd_op == 3'd2) |=> !ready); // R5

   AST_RPW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd1) |=> read_power); // R7

   AST_RPW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd0) |=> !read_power); // R7

   AST_BUSY_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && !ready) |=> $stable(read_power)); // R8

endmodule

bind nv_setting_ctrl nvs_checker #(
   .WIPER_W(WIPER_W),
   .NUM_CH (NUM_CH)
) u_nvs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .preset_n  (preset_n),
   .wprot_n   (wprot_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .wiper_pos (wiper_pos),
   .ready     (ready),
   .read_power(read_power)
);

// File: tb/test_nv_setting_ctrl.sv
module test_nv_setting_ctrl;

   localparam int LS  = 40;
   localparam int LRA = 12;
   localparam int LRD = 3;
   localparam int LP  = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             preset_n = 1'b1;
   logic             wprot_n = 1'b1;
   logic             cmd_valid = 1'b0;
   logic [2:0]       cmd_op = 3'd0;
   logic [3:0]       cmd_addr = 4'd0;
   logic [15:0]      cmd_data = 16'd0;
   logic [1:0][9:0]  wiper_pos;
   logic             ready;
   logic [15:0]      rd_data;
   logic             read_power;

   int    vec = 0;
   int    mis = 0;
   bit    cmp_en = 1'b0;
   string cur_req = "R2";

   // reference model state
   int m_mem [16];
   int m_wip [2];
   int m_busy = 0;
   bit m_pon = 1'b1;
   bit m_prq = 1'b1;
   int m_rd = 0;
   bit m_rpw = 1'b0;

   always #4 clk = ~clk;

   nv_setting_ctrl #(
      .LAT_STORE(LS), .LAT_RESTORE_ALL(LRA), .LAT_READ(LRD), .LAT_PRESET(LP)
   ) i_nv_setting_ctrl (
      .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .wprot_n(wprot_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .wiper_pos(wiper_pos), .ready(ready), .rd_data(rd_data), .read_power(read_power)
   );

   initial begin
      for (int i = 0; i < 16; i++) m_mem[i] = 512;
      m_wip[0] = 512;
      m_wip[1] = 512;
   end

   function automatic bit m_ready();
      return !m_pon && m_prq && (m_busy == 0);
   endfunction

   always @(posedge clk) begin : ref_model
      bit rdy;
      int ch;
      rdy = m_ready();
      ch  = int'(cmd_addr) & 1;
      if (!rst_n) begin
         m_wip[0] = 512; m_wip[1] = 512;
         m_busy = 0; m_pon = 1; m_prq = 1; m_rd = 0; m_rpw = 0;
      end else begin
         if (m_pon) begin
            m_wip[0] = m_mem[0] & 1023; m_wip[1] = m_mem[1] & 1023;
            m_pon = 0;
         end else if (!preset_n) begin
            m_wip[0] = 512; m_wip[1] = 512; m_busy = 0;
         end else if (!m_prq) begin
            m_wip[0] = m_mem[0] & 1023; m_wip[1] = m_mem[1] & 1023;
            m_busy = LP;
         end else begin
            if (m_busy > 0) m_busy--;
            if (cmd_valid && rdy) begin
               case (cmd_op)
                  3'd0: m_rpw = 0;
                  3'd1: begin m_wip[ch] = m_mem[ch] & 1023; m_rpw = 1; end
                  3'd2: if (wprot_n) begin m_mem[ch] = m_wip[ch]; m_busy = LS; end
                  3'd3: if (wprot_n && cmd_addr != 4'd15) begin
                           m_mem[cmd_addr] = int'(cmd_data); m_busy = LS;
                        end
                  3'd4: begin
                           m_wip[0] = m_mem[0] & 1023; m_wip[1] = m_mem[1] & 1023;
                           m_busy = LRA;
                        end
                  3'd5: begin m_rd = m_mem[cmd_addr]; m_busy = LRD; end
                  3'd6: begin m_rd = m_wip[ch]; m_busy = LRD; end
                  default: if (wprot_n) m_wip[ch] = int'(cmd_data) & 1023;
               endcase
            end
         end
         m_prq = preset_n;
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         vec++;
         if (ready !== m_ready()) begin
            mis++; $display("FAIL %s ready: actual %0d expected %0d", cur_req, ready, m_ready());
         end
         for (int c = 0; c < 2; c++) begin
            if (int'(wiper_pos[c]) != m_wip[c]) begin
               mis++; $display("FAIL %s wiper%0d: actual %0d expected %0d", cur_req, c, wiper_pos[c], m_wip[c]);
            end
         end
         if (int'(rd_data) != m_rd) begin
            mis++; $display("FAIL %s rd_data: actual %0d expected %0d", cur_req, rd_data, m_rd);
         end
         if (read_power !== m_rpw) begin
            mis++; $display("FAIL %s read_power: actual %0d expected %0d", cur_req, read_power, m_rpw);
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      vec++;
      if (act != exp) begin
         mis++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // drive one command for one cycle; returns at the negedge after the accepting edge
   task automatic cmd(input int op, input int addr, input int data);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = 4'(addr); cmd_data = 16'(data);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (!ready && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic wait_ready();
      int n;
      busy_len(n);
   endtask

   initial begin
      int n;
      @(negedge clk);
      cmp_en = 1'b1;
      @(negedge clk);
      cur_req = "R2";
      chk("R2", "ready in reset", int'(ready), 0);
      chk("R2", "wiper0 in reset", int'(wiper_pos[0]), 512);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", "ready after release", int'(ready), 1);
      chk("R2", "wiper1 unwritten entry", int'(wiper_pos[1]), 512);
      cmd(5, 9, 0);
      chk("R2", "unwritten user entry", int'(rd_data), 512);
      wait_ready();

      cur_req = "R10";
      cmd(7, 0, 256);
      cmd(7, 1, 677);
      chk("R10", "write wiper0", int'(wiper_pos[0]), 256);
      chk("R10", "write wiper1", int'(wiper_pos[1]), 677);

      cur_req = "R5";
      cmd(2, 0, 0);
      busy_len(n);
      chk("R5", "save busy cycles", n, LS);
      cmd(2, 1, 0);
      wait_ready();
      cmd(5, 1, 0);
      chk("R10", "read saved entry 1", int'(rd_data), 677);
      busy_len(n);
      chk("R5", "read busy cycles", n, LRD);

      cur_req = "R1";
      cmd(3, 5, 16'hBEEF);
      wait_ready();
      cmd(5, 5, 0);
      chk("R1", "user entry 5", int'(rd_data), 16'hBEEF);
      wait_ready();
      cmd(3, 15, 16'h1234);
      chk("R1", "reserved store keeps ready", int'(ready), 1);
      cmd(5, 15, 0);
      chk("R1", "reserved entry value", int'(rd_data), 512);
      wait_ready();

      cur_req = "R6";
      cmd(3, 0, 16'hFC05);
      wait_ready();
      cmd(1, 0, 0);
      chk("R6", "low bits of entry 0", int'(wiper_pos[0]), 5);
      chk("R7", "read_power after restore", int'(read_power), 1);
      cmd(6, 0, 0);
      chk("R10", "read wiper0", int'(rd_data), 5);
      wait_ready();
      cmd(0, 0, 0);
      chk("R7", "read_power after nop", int'(read_power), 0);

      cur_req = "R8";
      cmd(2, 1, 0);
      cmd(7, 1, 100);
      chk("R8", "write while busy ignored", int'(wiper_pos[1]), 677);
      cmd(1, 1, 0);
      chk("R8", "restore while busy ignored", int'(read_power), 0);
      wait_ready();

      cur_req = "R4";
      cmd(7, 0, 999);
      cmd(7, 1, 3);
      wprot_n = 1'b0;
      cmd(7, 0, 300);
      chk("R4", "protected wiper write", int'(wiper_pos[0]), 999);
      cmd(2, 0, 0);
      chk("R4", "protected save no busy", int'(ready), 1);
      cmd(3, 6, 16'h1111);
      chk("R4", "protected store no busy", int'(ready), 1);
      cmd(5, 6, 0);
      chk("R4", "protected user entry", int'(rd_data), 512);
      wait_ready();
      cmd(4, 0, 0);
      chk("R4", "restore-all under protect w0", int'(wiper_pos[0]), 5);
      chk("R4", "restore-all under protect w1", int'(wiper_pos[1]), 677);
      busy_len(n);
      chk("R5", "restore-all busy cycles", n, LRA);
      wprot_n = 1'b1;

      cur_req = "R3";
      cmd(7, 0, 123);
      @(negedge clk);
      preset_n = 1'b0;
      @(negedge clk);
      chk("R3", "preset low wiper0", int'(wiper_pos[0]), 512);
      chk("R3", "preset low ready", int'(ready), 0);
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = 4'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R8", "restore during preset ignored", int'(read_power), 0);
      @(negedge clk);
      preset_n = 1'b1;
      @(negedge clk);
      chk("R3", "preset release wiper0", int'(wiper_pos[0]), 5);
      chk("R3", "preset release wiper1", int'(wiper_pos[1]), 677);
      busy_len(n);
      chk("R3", "preset busy cycles", n, LP);

      cur_req = "R9";
      cmd(7, 0, 50);
      @(negedge clk);
      rst_n = 1'b0;
      preset_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R2", "wiper0 during reset", int'(wiper_pos[0]), 512);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "power-on load beats preset", int'(wiper_pos[0]), 5);
      @(negedge clk);
      chk("R9", "preset follows power-on", int'(wiper_pos[1]), 512);
      preset_n = 1'b1;
      @(negedge clk);
      wait_ready();

      cur_req = "R2";
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", "power-on wiper0 from store", int'(wiper_pos[0]), 5);
      chk("R2", "power-on wiper1 from store", int'(wiper_pos[1]), 677);
      chk("R2", "ready after power-on", int'(ready), 1);
      repeat (3) @(negedge clk);

      cmp_en = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      mis++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
   end

endmodule